// File: doc/BRIEF.md
# SPI Master Chip-Select Hold Controller

This block is the transmit side of an SPI master that drives four active-low chip selects. The host writes a data byte and a 2-bit target select into a single holding register. The word moves into a shift register and goes out MSB first in SPI mode 0. The serial clock runs at one quarter of the system clock. The holding-register-empty flag rises as soon as the word has moved into the shifter. This lets the host queue the next byte while the current one is still shifting.

The main job of the block is to decide, for back-to-back words, whether a select stays low or is released. Each select has its own configuration: an inter-transfer delay counted in system clock cycles, and a hold-active bit that keeps the line low after a word even when no new data arrives. A one-shot last-transfer control, set before the final byte is written, forces a clean release after that byte. A request to a different select always releases the current one first, so at most one line is ever low.

Top module: `spi_cs_hold_ctrl`

## Requirements
- R1: After reset all chip selects are high, sck and mosi are low, and hr_empty is high.
- R2: Each word is 8 bits, sent MSB first in mode 0. mosi is stable while sck is high, and sck has a period of 4 system clocks, so one word takes 32 clocks. sck stays low whenever every select is high.
- R3: On an idle link, an accepted write leaves hr_empty low for one cycle. In the next cycle hr_empty is high again while the target select is already low and the word is shifting.
- R4: A write is accepted only while hr_empty is high. A write made while it is low is ignored and transmits nothing.
- R5: If a new word for the same select is written before the current word and its delay complete, the select stays low across both words: one low span of 2*(33+D) cycles, where D is that select's delay field.
- R6: With hold-active at 0 and no new word queued, a select that starts a word stays low for exactly 33+D cycles: 32 shift cycles plus D+1 gap cycles. Each select uses its own D.
- R7: With hold-active at 1, the select stays low after its word for as long as no word for another select is queued.
- R8: When a word targets a different select than the one that is low, the old select goes high, all selects stay high for exactly one cycle, and then the new select goes low. Two selects are never low at once.
- R9: If last_set is pulsed before a word is written, the select is released 33+D cycles after that word starts, even when hold-active is 1.
- R10: The last-transfer control clears itself once the release it caused has happened. The next word on a held select then keeps the line low again.
- R11: A delay field of 0 is legal and gives the shortest low span of 33 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for one select's configuration |
| cfg_idx | input | 2 | Select whose configuration is written |
| cfg_dly | input | 8 | Inter-transfer delay D in system clocks |
| cfg_hold | input | 1 | Hold-active bit: keep select low after a word |
| last_set | input | 1 | Pulse to arm release after the next written word |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| wr_cs | input | 2 | Target select for this byte |
| hr_empty | output | 1 | Holding register can accept a write |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out, MSB first |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The bound checker watches, on every cycle, the invariants of the select lines and the serial pins. It checks that at most one select is low, that a low select never jumps straight to another, that sck is idle while all selects are high, that mosi is stable during the high phase of sck, and that an accepted write makes hr_empty fall. The exact span lengths depend on timing and history, so only the bench scenarios show them: the 33+D and 2*(33+D) spans, indefinite holding, the release forced by last_set and its self-clearing, the single all-high cycle at a select change, and the byte that arrives at each select. The bench sweeps every select over several delay values and computes each expected span by arithmetic.

// File: rtl/spi_csh_pkg.sv
package spi_csh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } csh_state_t;
endpackage

// File: rtl/spi_csh_cfg_bank.sv
module spi_csh_cfg_bank #(
  parameter int NUM_CS = 4,
  parameter int DLY_W  = 8,
  localparam int CS_W  = $clog2(NUM_CS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [CS_W-1:0]         idx,
  input  logic [DLY_W-1:0]        dly_in,
  input  logic                    hold_in,
  output logic [NUM_CS*DLY_W-1:0] dly_all,
  output logic [NUM_CS-1:0]       hold_all
);
  // one configuration slot per select
  for (genvar g = 0; g < NUM_CS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        dly_all[g*DLY_W +: DLY_W] <= '0;
        hold_all[g]               <= 1'b0;
      end else if (we && idx == CS_W'(g)) begin
        dly_all[g*DLY_W +: DLY_W] <= dly_in;
        hold_all[g]               <= hold_in;
      end
    end
  end
endmodule

// File: rtl/spi_csh_shifter.sv
module spi_csh_shifter #(
  parameter int DATA_W  = 8,
  parameter int SCK_DIV = 4,
  localparam int TOTAL  = DATA_W * SCK_DIV,
  localparam int CNT_W  = $clog2(TOTAL),
  localparam int PH_W   = $clog2(SCK_DIV)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              sck,
  output logic              mosi,
  output logic              busy,
  output logic              done
);
  logic [DATA_W-1:0] sr;
  logic [CNT_W-1:0]  cnt;
  logic [PH_W-1:0]   phase;

  assign phase = cnt[PH_W-1:0];
  assign done  = busy && (cnt == CNT_W'(TOTAL - 1));
  // mode 0: low half first, data sampled on the rising edge
  assign sck   = busy && (phase >= PH_W'(SCK_DIV / 2));
  assign mosi  = sr[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      cnt  <= '0;
      busy <= 1'b0;
    end else if (load) begin
      sr   <= load_data;
      cnt  <= '0;
      busy <= 1'b1;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (done) begin
        busy <= 1'b0;
        sr   <= '0;
      end else if (phase == PH_W'(SCK_DIV - 1)) begin
        sr <= {sr[DATA_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_cs_hold_ctrl.sv
module spi_cs_hold_ctrl
  import spi_csh_pkg::*;
#(
  parameter int NUM_CS  = 4,
  parameter int DATA_W  = 8,
  parameter int DLY_W   = 8,
  parameter int SCK_DIV = 4,
  localparam int CS_W   = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CS_W-1:0]   cfg_idx,
  input  logic [DLY_W-1:0]  cfg_dly,
  input  logic              cfg_hold,
  input  logic              last_set,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CS_W-1:0]   wr_cs,
  output logic              hr_empty,
  output logic              sck,
  output logic              mosi,
  output logic [NUM_CS-1:0] cs_n
);
  logic [NUM_CS*DLY_W-1:0] dly_all;
  logic [NUM_CS-1:0]       hold_all;

  // holding register
  logic              hr_full;
  logic [DATA_W-1:0] hr_data;
  logic [CS_W-1:0]   hr_cs;
  logic              hr_last;

  // select sequencer state
  csh_state_t       state;
  logic             cs_on;
  logic [CS_W-1:0]  cs_act;
  logic             cur_last;
  logic             last_pend;
  logic [DLY_W-1:0] gap_cnt;

  logic sh_busy, sh_done;
  logic load_go, rel_go, drop_go, rel_last;

  spi_csh_cfg_bank #(.NUM_CS(NUM_CS), .DLY_W(DLY_W)) cfg_i (
    .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx),
    .dly_in(cfg_dly), .hold_in(cfg_hold),
    .dly_all(dly_all), .hold_all(hold_all)
  );

  spi_csh_shifter #(.DATA_W(DATA_W), .SCK_DIV(SCK_DIV)) shf_i (
    .clk(clk), .rst(rst), .load(load_go), .load_data(hr_data),
    .sck(sck), .mosi(mosi), .busy(sh_busy), .done(sh_done)
  );

  assign hr_empty = !hr_full;

  // decide load / release / switch-drop for this cycle
  always_comb begin
    load_go  = 1'b0;
    rel_go   = 1'b0;
    drop_go  = 1'b0;
    rel_last = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (hr_full) begin
          if (cs_on && hr_cs != cs_act) drop_go = 1'b1;
          else                          load_go = 1'b1;
        end
      end
      ST_GAP: begin
        if (gap_cnt == '0) begin
          if (cur_last) begin
            rel_go   = 1'b1;
            rel_last = 1'b1;
          end else if (hr_full && hr_cs == cs_act) begin
            load_go = 1'b1;
          end else if (!hold_all[cs_act]) begin
            rel_go = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hr_full   <= 1'b0;
      hr_data   <= '0;
      hr_cs     <= '0;
      hr_last   <= 1'b0;
      state     <= ST_IDLE;
      cs_on     <= 1'b0;
      cs_act    <= '0;
      cur_last  <= 1'b0;
      last_pend <= 1'b0;
      gap_cnt   <= '0;
    end else begin
      // host side: accept only into an empty holding register
      if (wr_en && !hr_full) begin
        hr_full <= 1'b1;
        hr_data <= wr_data;
        hr_cs   <= wr_cs;
        hr_last <= last_pend || last_set;
      end else if (load_go) begin
        hr_full <= 1'b0;
      end

      if (last_set)      last_pend <= 1'b1;
      else if (rel_last) last_pend <= 1'b0;

      if (load_go) begin
        cs_act   <= hr_cs;
        cs_on    <= 1'b1;
        cur_last <= hr_last;
      end else if (rel_go || drop_go) begin
        cs_on <= 1'b0;
      end

      unique case (state)
        ST_IDLE:  if (load_go) state <= ST_SHIFT;
        ST_SHIFT: begin
          if (sh_done) begin
            state   <= ST_GAP;
            gap_cnt <= dly_all[cs_act*DLY_W +: DLY_W];
          end
        end
        ST_GAP: begin
          if (gap_cnt != '0)  gap_cnt <= gap_cnt - 1'b1;
          else if (load_go)   state   <= ST_SHIFT;
          else                state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // select lines decoded from sequencer flops only
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = !(cs_on && cs_act == CS_W'(g));
  end
endmodule

// File: rtl/spi_cs_hold_ctrl_chk.sv
module spi_cs_hold_ctrl_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              hr_empty,
  input logic              sck,
  input logic              mosi,
  input logic [NUM_CS-1:0] cs_n
);
  // R8
  one_low_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  // R8
  no_direct_switch_chk: assert property (@(posedge clk) disable iff (rst)
    (!(&$past(cs_n)) && !(&cs_n)) |-> (cs_n == $past(cs_n)));

  // R2
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (&cs_n) |-> !sck);

  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(mosi));

  // R4
  accept_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hr_empty) |=> !hr_empty);
endmodule

bind spi_cs_hold_ctrl spi_cs_hold_ctrl_chk #(.NUM_CS(NUM_CS)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .hr_empty(hr_empty),
  .sck(sck), .mosi(mosi), .cs_n(cs_n)
);

// File: tb/spi_cs_hold_ctrl_tb_top.sv
module spi_cs_hold_ctrl_tb_top;
  localparam int NCS = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_idx = '0;
  logic [7:0] cfg_dly = '0;
  logic       cfg_hold = 1'b0;
  logic       last_set = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] wr_cs = '0;
  logic       hr_empty, sck, mosi;
  logic [3:0] cs_n;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  spi_cs_hold_ctrl dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_dly(cfg_dly), .cfg_hold(cfg_hold), .last_set(last_set),
    .wr_en(wr_en), .wr_data(wr_data), .wr_cs(wr_cs),
    .hr_empty(hr_empty), .sck(sck), .mosi(mosi), .cs_n(cs_n)
  );

  // ---------------- monitor (samples at negedge) ----------------
  int         cyc = 0;
  logic [3:0] prev_csn = 4'hF;
  logic       prev_sck = 1'b0;
  int         start_t[NCS];
  int         rise_t[NCS];
  int         span[NCS];
  int         rises[NCS];
  int         multi_low = 0;
  int         bad_period = 0;
  int         last_rise = 0;
  int         nbits = 0;
  logic [7:0] shreg = '0;
  logic [7:0] rx_data[64];
  int         rx_cs[64];
  int         rx_n = 0;

  initial begin
    for (int i = 0; i < NCS; i++) begin
      start_t[i] = 0; rise_t[i] = 0; span[i] = 0; rises[i] = 0;
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      for (int i = 0; i < NCS; i++) begin
        if (prev_csn[i] && !cs_n[i]) start_t[i] = cyc;
        if (!prev_csn[i] && cs_n[i]) begin
          span[i]   = cyc - start_t[i];
          rise_t[i] = cyc;
          rises[i]  = rises[i] + 1;
        end
      end
      if ($countones(~cs_n) > 1) multi_low = multi_low + 1;
      if (!prev_sck && sck) begin
        if (nbits != 0 && (cyc - last_rise) != 4) bad_period = bad_period + 1;
        last_rise = cyc;
        shreg = {shreg[6:0], mosi};
        nbits = nbits + 1;
        if (nbits == 8) begin
          nbits = 0;
          rx_data[rx_n % 64] = shreg;
          rx_cs[rx_n % 64] = -1;
          for (int i = 0; i < NCS; i++) if (!cs_n[i]) rx_cs[rx_n % 64] = i;
          rx_n = rx_n + 1;
        end
      end
    end
    prev_csn = cs_n;
    prev_sck = sck;
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input int c, input int d, input bit h);
    cfg_we = 1'b1; cfg_idx = 2'(c); cfg_dly = 8'(d); cfg_hold = h;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic host_write(input logic [7:0] v, input int c);
    while (!hr_empty) tick(1);
    wr_en = 1'b1; wr_data = v; wr_cs = 2'(c);
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic pulse_last();
    last_set = 1'b1;
    tick(1);
    last_set = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int n0, r0;
    logic [7:0] v;
    tick(4);
    // R1 reset state
    check(cs_n == 4'hF, "R1 cs_n after reset", int'(cs_n), 15);
    check(sck == 1'b0 && mosi == 1'b0, "R1 sck/mosi idle", int'({sck, mosi}), 0);
    check(hr_empty == 1'b1, "R1 hr_empty", int'(hr_empty), 1);
    rst = 1'b0;
    tick(2);

    // R6 / R11 / R2 sweep over every select and several delays
    for (int c = 0; c < NCS; c++) begin
      for (int k = 0; k < 3; k++) begin
        int d;
        d = (k == 2) ? 5 : k;
        v = 8'(8'hA5 ^ (c * 37 + k * 11));
        cfg_write(c, d, 1'b0);
        n0 = rx_n; r0 = rises[c];
        host_write(v, c);
        tick(45 + d);
        check(span[c] == 33 + d, (d == 0) ? "R11 zero-delay span" : "R6 span 33+D",
              span[c], 33 + d);
        check(rises[c] == r0 + 1, "R6 single release", rises[c], r0 + 1);
        check(rx_n == n0 + 1 && rx_data[n0 % 64] == v, "R2 byte MSB first",
              int'(rx_data[n0 % 64]), int'(v));
        check(rx_cs[n0 % 64] == c, "R2 byte on target select", rx_cs[n0 % 64], c);
      end
    end
    check(bad_period == 0, "R2 sck period 4", bad_period, 0);

    // R3 hr_empty rises while word shifts
    cfg_write(0, 2, 1'b0);
    wr_en = 1'b1; wr_data = 8'h3C; wr_cs = 2'd0;
    tick(1);
    wr_en = 1'b0;
    check(hr_empty == 1'b0, "R3 hr_empty low after write", int'(hr_empty), 0);
    tick(1);
    check(hr_empty == 1'b1 && cs_n[0] == 1'b0, "R3 hr_empty high while shifting",
          int'({hr_empty, cs_n[0]}), 2);
    tick(50);

    // R4 write while full is ignored
    n0 = rx_n;
    wr_en = 1'b1; wr_data = 8'h81; wr_cs = 2'd0;
    tick(1);
    wr_data = 8'h7E;
    tick(1);
    wr_en = 1'b0;
    tick(60);
    check(rx_n == n0 + 1, "R4 only one word sent", rx_n - n0, 1);
    check(rx_data[n0 % 64] == 8'h81, "R4 first byte kept", int'(rx_data[n0 % 64]), 129);

    // R5 reload before end keeps select low
    cfg_write(2, 2, 1'b0);
    n0 = rx_n; r0 = rises[2];
    host_write(8'hC3, 2);
    host_write(8'h5A, 2);
    tick(90);
    check(span[2] == 2 * 35, "R5 merged span", span[2], 70);
    check(rises[2] == r0 + 1, "R5 one release", rises[2], r0 + 1);
    check(rx_n == n0 + 2 && rx_data[(n0 + 1) % 64] == 8'h5A, "R5 second byte",
          int'(rx_data[(n0 + 1) % 64]), 90);

    // R7 hold-active keeps select low with no data
    cfg_write(1, 0, 1'b1);
    r0 = rises[1];
    host_write(8'h11, 1);
    tick(150);
    check(cs_n[1] == 1'b0, "R7 held low", int'(cs_n[1]), 0);
    check(rises[1] == r0, "R7 no release", rises[1], r0);

    // R8 switch target: one all-high cycle between selects
    cfg_write(3, 0, 1'b0);
    host_write(8'h22, 3);
    tick(60);
    check(start_t[3] - rise_t[1] == 1, "R8 one-cycle gap on switch",
          start_t[3] - rise_t[1], 1);
    check(span[3] == 33, "R8 new select span", span[3], 33);

    // R9 last transfer overrides hold
    cfg_write(0, 1, 1'b1);
    r0 = rises[0];
    pulse_last();
    host_write(8'h99, 0);
    tick(120);
    check(span[0] == 34 && rises[0] == r0 + 1, "R9 released after last word",
          span[0], 34);
    check(cs_n[0] == 1'b1, "R9 stays high", int'(cs_n[0]), 1);

    // R10 last control cleared: next word is held again
    r0 = rises[0];
    host_write(8'h44, 0);
    tick(150);
    check(cs_n[0] == 1'b0 && rises[0] == r0, "R10 held after auto-clear",
          int'(cs_n[0]), 0);
    pulse_last();
    host_write(8'h55, 0);
    tick(80);
    check(cs_n[0] == 1'b1, "R10 last rearms release", int'(cs_n[0]), 1);

    check(multi_low == 0, "R8 never two selects low", multi_low, 0);
    check(bad_period == 0, "R2 sck period over run", bad_period, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule